// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the status byte of a small 8-bit microcontroller core. The low nibble carries the arithmetic flags (carry, half-carry, zero, overflow). The ALU presents each result here together with its operands, its carry-out and an operation class, and the block works out the flags. The next two bits record system events: a power-down flag raised by the halt instruction, and a timeout flag raised by the watchdog. The top two bits always read zero.

Subtraction follows the inverted-borrow convention. The ALU computes `a + ~b + 1`, so its carry-out is 1 when no borrow occurs. The half-carry flag likewise reads 1 when no borrow crosses from bit 4 into the low nibble. Software may write the arithmetic nibble over the register bus. The two system flags cannot be written and change only on the event strobes.

The core reads the current carry on `carry_o` for add-with-carry and rotate-through-carry operations. The bus reads the whole byte combinationally on `rd_data_o`.

Top module: `alu_status_reg`

## Requirements
- R1: On an add (op class 0) or subtract (op class 1) with `op_valid_i` high, carry (bit 0) takes `cout_i` on the next clock edge. On a subtract this means 1 when the first operand is at least the second, unsigned.
- R2: On an add, half-carry (bit 1) is set when the low four bits of the operands sum above 15. On a subtract, it is set when the low nibble of the first operand is at least the low nibble of the second.
- R3: On an add, a subtract or a logic operation (op class 2), zero (bit 2) is set exactly when `res_i` is 0.
- R4: On an add or subtract, overflow (bit 3) is set when the signed result falls outside the 8-bit two's-complement range. This is the case when the carry into bit 7 differs from the carry out of bit 7.
- R5: A logic operation changes only the zero flag. A rotate-through-carry (op class 3) changes only the carry flag, which takes `cout_i`.
- R6: The power-down flag (bit 4) is set by `halt_i` and cleared by `pwr_up_i` or `wdt_clr_i`.
- R7: The timeout flag (bit 5) is set by `wdt_to_i` and cleared by `pwr_up_i`, `wdt_clr_i` or `halt_i`.
- R8: When a set event and a clear event for the same system flag arrive in the same cycle, the set wins.
- R9: A bus write (`wr_en_i`) loads bits 0 to 3 from `wr_data_i[3:0]`, overriding any ALU update in the same cycle. Bits 4 and 5 are left unchanged by the write.
- R10: Bits 7 and 6 always read 0. `rd_data_o` equals `flags_o`, and `carry_o` equals bit 0.
- R11: Reset clears the whole byte. With no operation, no write and no event, the byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | ALU result valid this cycle |
| op_class_i | input | 2 | 0 add, 1 subtract, 2 logic, 3 rotate through carry |
| opa_i | input | 8 | First ALU operand |
| opb_i | input | 8 | Second ALU operand (subtrahend on subtract) |
| res_i | input | 8 | ALU result |
| cout_i | input | 1 | ALU carry-out, or the bit rotated out |
| pwr_up_i | input | 1 | Power-up event strobe |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| wdt_to_i | input | 1 | Watchdog timeout strobe |
| wr_en_i | input | 1 | Register bus write enable |
| wr_data_i | input | 8 | Register bus write data |
| rd_data_o | output | 8 | Register bus read data |
| flags_o | output | 8 | Status byte |
| carry_o | output | 1 | Carry fed back to the ALU |

## Verification
The assertions check the following on every cycle:
- a bus write always lands in the arithmetic nibble;
- the flags outside an operation's update mask stay still;
- carry and zero track the ALU's carry-out and result;
- the system flags follow their set, clear and set-wins rules;
- an idle cycle holds the register.

Only the bench's scenarios can show that the half-carry and overflow values are arithmetically right. The bench sweeps every first operand against a spread of second operands for both add and subtract, and compares with limits computed from the operand values. Scripted event sequences cover the interplay of write priority, logic and rotate masking, and event collisions.

// File: rtl/alu_stat_pkg.sv
package alu_stat_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_ROT   = 2'd3
  } op_class_e;

  localparam int unsigned C_POS  = 0;
  localparam int unsigned AC_POS = 1;
  localparam int unsigned Z_POS  = 2;
  localparam int unsigned OV_POS = 3;
  localparam int unsigned PD_POS = 4;
  localparam int unsigned TO_POS = 5;
  localparam int unsigned AR_W   = 4;
  localparam int unsigned STAT_W = 8;

  typedef struct packed {
    logic ov;
    logic z;
    logic ac;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
  import alu_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  op_class_e            op_class_i,
  input  logic [DATA_W-1:0]    opa_i,
  input  logic [DATA_W-1:0]    opb_i,
  input  logic [DATA_W-1:0]    res_i,
  input  logic                 cout_i,
  output arith_flags_t         nxt_o,
  output logic [AR_W-1:0]      mask_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              cin_nib;
  logic              cin_msb;

  // subtract is a + ~b + 1, so carries read as inverted borrows
  assign b_eff   = (op_class_i == OP_SUB) ? ~opb_i : opb_i;
  assign cin_nib = opa_i[NIB_W] ^ b_eff[NIB_W] ^ res_i[NIB_W];
  assign cin_msb = opa_i[MSB] ^ b_eff[MSB] ^ res_i[MSB];

  always_comb begin
    nxt_o.c  = cout_i;
    nxt_o.ac = cin_nib;
    nxt_o.z  = (res_i == '0);
    nxt_o.ov = cin_msb ^ cout_i;
    unique case (op_class_i)
      OP_ADD, OP_SUB: mask_o = 4'b1111;
      OP_LOGIC:       mask_o = 4'b0100;
      default:        mask_o = 4'b0001;
    endcase
  end

  always_comb begin
    if (op_class_i == OP_LOGIC) begin
      AST_LOGIC_MASK: assert ($countones(mask_o) == 1 && mask_o[Z_POS]) else $error("logic mask"); // R5
    end
  end
endmodule

// File: rtl/arith_flag_reg.sv
module arith_flag_reg
  import alu_stat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [AR_W-1:0] mask_i,
  input  arith_flags_t    nxt_i,
  input  logic            wr_en_i,
  input  logic [AR_W-1:0] wr_data_i,
  output logic [AR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= wr_data_i;
    else if (upd_i)   q_o <= (q_o & ~mask_i) | (nxt_i & mask_i);
  end

  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> q_o == $past(wr_data_i)) else $error("write lost"); // R9
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !wr_en_i |=> ((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0) else $error("masked flag moved"); // R5
  AST_AR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i && !wr_en_i |=> $stable(q_o)) else $error("arith flags drift"); // R11
endmodule

// File: rtl/sys_flag_reg.sv
module sys_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_up_i,
  input  logic wdt_clr_i,
  input  logic halt_i,
  input  logic wdt_to_i,
  output logic pdf_o,
  output logic to_o
);
  logic pdf_clr, to_clr;

  assign pdf_clr = pwr_up_i | wdt_clr_i;
  assign to_clr  = pwr_up_i | wdt_clr_i | halt_i;

  // set dominates clear on both flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdf_o <= 1'b0;
      to_o  <= 1'b0;
    end else begin
      if (halt_i)       pdf_o <= 1'b1;
      else if (pdf_clr) pdf_o <= 1'b0;
      if (wdt_to_i)     to_o  <= 1'b1;
      else if (to_clr)  to_o  <= 1'b0;
    end
  end

  AST_PDF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> pdf_o) else $error("pdf not set"); // R6
  AST_PDF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_up_i || wdt_clr_i) && !halt_i |=> !pdf_o) else $error("pdf not cleared"); // R6
  AST_TO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_i |=> to_o) else $error("to not set"); // R7
  AST_TO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_up_i || wdt_clr_i || halt_i) && !wdt_to_i |=> !to_o) else $error("to not cleared"); // R7
  AST_TO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_i && (halt_i || wdt_clr_i || pwr_up_i) |=> to_o && $rose(to_o) || $past(to_o)) else $error("collision"); // R8
  AST_SYS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_up_i || wdt_clr_i || halt_i || wdt_to_i) |=> $stable(pdf_o) && $stable(to_o)) else $error("sys drift"); // R11
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_class_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  input  logic              pwr_up_i,
  input  logic              wdt_clr_i,
  input  logic              halt_i,
  input  logic              wdt_to_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] flags_o,
  output logic              carry_o
);
  op_class_e       cls;
  arith_flags_t    nxt;
  logic [AR_W-1:0] mask;
  logic [AR_W-1:0] ar_q;
  logic            pdf_q, to_q;
  logic            unused_wr_hi;

  assign cls          = op_class_e'(op_class_i);
  assign unused_wr_hi = ^wr_data_i[STAT_W-1:AR_W];

  alu_flag_calc #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_calc (
    .op_class_i(cls),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .res_i     (res_i),
    .cout_i    (cout_i),
    .nxt_o     (nxt),
    .mask_o    (mask)
  );

  arith_flag_reg u_ar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (op_valid_i),
    .mask_i   (mask),
    .nxt_i    (nxt),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i[AR_W-1:0]),
    .q_o      (ar_q)
  );

  sys_flag_reg u_sys (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_up_i (pwr_up_i),
    .wdt_clr_i(wdt_clr_i),
    .halt_i   (halt_i),
    .wdt_to_i (wdt_to_i),
    .pdf_o    (pdf_q),
    .to_o     (to_q)
  );

  assign flags_o   = {2'b00, to_q, pdf_q, ar_q};
  assign rd_data_o = flags_o;
  assign carry_o   = flags_o[C_POS];

  AST_CARRY_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !wr_en_i && cls != OP_LOGIC |=> carry_o == $past(cout_i)) else $error("carry"); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !wr_en_i && cls != OP_ROT |=> flags_o[Z_POS] == ($past(res_i) == '0)) else $error("zero"); // R3
  AST_SYS_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !(pwr_up_i || wdt_clr_i || halt_i || wdt_to_i) |=> $stable(flags_o[TO_POS:PD_POS])) else $error("sys written"); // R9
endmodule

// File: tb/sim_alu_status_reg.sv
module sim_alu_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_class = 2'd0;
  logic [7:0] opa = '0, opb = '0, res = '0;
  logic       cout = 1'b0;
  logic       pwr_up = 1'b0, wdt_clr = 1'b0, halt = 1'b0, wdt_to = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, flags;
  logic       carry;
  int         total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  alu_status_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_class_i(op_class),
    .opa_i(opa), .opb_i(opb), .res_i(res), .cout_i(cout),
    .pwr_up_i(pwr_up), .wdt_clr_i(wdt_clr), .halt_i(halt), .wdt_to_i(wdt_to),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .flags_o(flags),
    .carry_o(carry)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result visible at the next falling edge
  task automatic step();
    @(negedge clk);
    op_valid = 0; wr_en = 0; pwr_up = 0; wdt_clr = 0; halt = 0; wdt_to = 0;
  endtask

  task automatic alu(input logic [1:0] cls, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] r, input logic co);
    op_valid = 1; op_class = cls; opa = a; opb = b; res = r; cout = co;
    step();
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] ex;
    @(negedge clk);
    chk("R11 reset", flags, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset read", rd_data, 8'h00);
    chk("R10 reset carry", {7'b0, carry}, 8'h00);

    // R1 R2 R3 R4 add sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 4) begin
        int s;
        s = a + b;
        ex = 8'h00;
        ex[0] = s > 255;
        ex[1] = ((a % 16) + (b % 16)) > 15;
        ex[2] = (s % 256) == 0;
        ex[3] = ((a < 128) == (b < 128)) && (((s % 256) < 128) != (a < 128));
        alu(2'd0, 8'(a), 8'(b), 8'(s), s > 255);
        chk("R1 R2 R3 R4 add", flags, ex);
      end
    end
    // R1 R2 R3 R4 subtract sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 1; b < 256; b += 4) begin
        int d;
        d = (a - b + 256) % 256;
        ex = 8'h00;
        ex[0] = a >= b;
        ex[1] = (a % 16) >= (b % 16);
        ex[2] = d == 0;
        ex[3] = ((a < 128) != (b < 128)) && ((d < 128) != (a < 128));
        alu(2'd1, 8'(a), 8'(b), 8'(d), a >= b);
        chk("R1 R2 R3 R4 sub", flags, ex);
      end
    end
    alu(2'd1, 8'd77, 8'd77, 8'd0, 1'b1);
    chk("R1 R3 sub equal", flags, 8'h07);

    // R9 R10 write with upper bits set
    wr_en = 1; wr_data = 8'hFF; step();
    chk("R9 R10 write", flags, 8'h0F);
    chk("R10 carry out", {7'b0, carry}, 8'h01);
    // R5 logic updates only zero
    alu(2'd2, 8'h12, 8'h34, 8'h5A, 1'b0);
    chk("R5 R3 logic nonzero", flags, 8'h0B);
    alu(2'd2, 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R5 R3 logic zero", flags, 8'h0F);
    // R5 rotate updates only carry
    alu(2'd3, 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R5 rotate", flags, 8'h0E);
    chk("R10 carry follows", {7'b0, carry}, 8'h00);
    alu(2'd3, 8'h80, 8'h00, 8'h01, 1'b1);
    chk("R5 rotate set", flags, 8'h0F);
    // R9 write beats ALU
    op_valid = 1; op_class = 2'd0; opa = 0; opb = 0; res = 0; cout = 0;
    wr_en = 1; wr_data = 8'h35; step();
    chk("R9 write wins", flags, 8'h05);
    // R11 idle hold
    step(); step();
    chk("R11 idle", flags, 8'h05);

    // R6 R7 system events
    halt = 1; step();
    chk("R6 halt sets pdf", flags, 8'h15);
    wdt_to = 1; step();
    chk("R7 timeout", flags, 8'h35);
    wr_en = 1; wr_data = 8'h00; step();
    chk("R9 sys read only", flags, 8'h30);
    halt = 1; step();
    chk("R7 halt clears to", flags, 8'h10);
    wdt_clr = 1; step();
    chk("R6 clr clears pdf", flags, 8'h00);
    wdt_to = 1; halt = 1; step();
    chk("R8 to beats halt", flags, 8'h30);
    wdt_to = 1; wdt_clr = 1; step();
    chk("R8 to beats clr", flags, 8'h20);
    halt = 1; wdt_clr = 1; step();
    chk("R8 halt beats clr", flags, 8'h10);
    wdt_to = 1; step();
    pwr_up = 1; step();
    chk("R6 R7 power up", flags, 8'h00);
    wdt_to = 1; pwr_up = 1; step();
    chk("R8 to beats power up", flags, 8'h20);
    chk("R10 read mirror", rd_data, 8'h20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule